// File: doc/BRIEF.md
# Clock Frequency Source Selector

This block decides which frequency setting a clock synthesizer runs from. Five strap pins are captured while a power-good strobe is high. A software select code can override the strapped code. A programmable mode replaces the code-derived CPU frequency with an N/M divider pair, while the chosen code still sets the gear constant and the ratio of the other clock groups. When a watchdog reports a recovery condition, the block falls back either to the strapped code or to a separate recovery N/M pair. The synthesizer reads the active code, N, M and mode flag. A one-cycle pulse tells it when the active setting has moved.

Software reaches the block through a small byte-wide write port. Address 0 holds the select code in bits 4:0, the override bit in bit 5 and the programmable-mode enable in bit 6. Address 1 holds N. Address 2 holds M in bits 6:0. Address 3 holds the recovery N. Address 4 holds the recovery M in bits 6:0 and the recovery-source select in bit 7. Addresses 5 to 7 are not mapped.

The active setting is re-evaluated on every cycle. A write to N alone, or to M alone, is therefore enough to start a frequency load. Software that must avoid a transient pair has to write the two registers back to back.

Top module: `clk_src_select`

## Requirements
- R1: `strap_latched` copies `strap_code` on each rising clock edge on which `pwr_good` is 1. While `pwr_good` is 0 it holds its value.
- R2: Outside recovery, `ratio_code` equals the latched strap code when the override bit (address 0 bit 5) is 0. It equals the select code (address 0 bits 4:0) when the override bit is 1.
- R3: When the programmable-mode enable (address 0 bit 6) is 0 and no recovery is in effect, `prog_mode` is 0 and `cpu_n` and `cpu_m` are both 0.
- R4: When the programmable-mode enable is 1, `prog_mode` is 1 and `cpu_n`/`cpu_m` show the N (address 1) and M (address 2 bits 6:0) registers. `ratio_code` still follows R2.
- R5: A candidate programmed pair with N+3 not greater than M+3 (N ≤ M) sets `setting_err` to 1 and leaves all active outputs at their previous values. The first valid candidate afterwards clears `setting_err` and is applied.
- R6: While `wd_recover` is 1 and the recovery-source select (address 4 bit 7) is 0, `ratio_code` is the latched strap code and `prog_mode`, `cpu_n` and `cpu_m` are 0, whatever the override and enable bits hold.
- R7: While `wd_recover` is 1 and the recovery-source select is 1, `prog_mode` is 1, `cpu_n`/`cpu_m` are the recovery pair (address 3, address 4 bits 6:0), and `ratio_code` follows R2.
- R8: `freq_change` is high for exactly one cycle on the cycle after the active setting changes. A write that leaves the setting unchanged produces no pulse.
- R9: No `freq_change` pulse is produced while `wd_recover` is 1. Leaving recovery to a different setting produces one pulse.
- R10: After reset, all outputs are 0, and the override bit, enable bit, N, M, recovery pair and recovery select are all 0.
- R11: Writes to unmapped addresses 5, 6 and 7 change no output.
- R12: Writing only N or only M while programmable mode is on applies the new value of that register, paired with the other register's current value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pwr_good | input | 1 | Power-good strobe; straps are sampled while high |
| strap_code | input | 5 | Strap pin levels |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| wd_recover | input | 1 | Watchdog recovery lock, level |
| strap_latched | output | 5 | Latched strap copy |
| ratio_code | output | 5 | Active ratio / gear code |
| cpu_n | output | 8 | Active N value (0 when not programmable) |
| cpu_m | output | 7 | Active M value (0 when not programmable) |
| prog_mode | output | 1 | Active setting uses N/M |
| setting_err | output | 1 | Current candidate N/M pair is invalid |
| freq_change | output | 1 | One-cycle pulse after the active setting changes |

## Verification
A register write or a strap capture lands on the first rising edge. The active outputs, `setting_err` and `freq_change` follow on the second rising edge, so each result is due two edges after the stimulus. A change of `wd_recover` is due one edge after it is applied. The bench drives every stimulus on a falling edge and applies the recovery level only after the write edge, so that writes and recovery line up on the same commit edge. It samples on the falling edge after that second rising edge, which is the only cycle in which the matching `freq_change` pulse can be seen. The directed tests reuse the same timing, except that the reset check samples while reset is still asserted.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  localparam int CODE_W = 5;
  localparam int N_W    = 8;
  localparam int M_W    = 7;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  localparam int CTRL_OVR_BIT  = 5;
  localparam int CTRL_PROG_BIT = 6;
  localparam int RM_SEL_BIT    = 7;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_N    = 3'd1,
    A_M    = 3'd2,
    A_RN   = 3'd3,
    A_RM   = 3'd4
  } cfg_addr_e;

  typedef struct packed {
    logic              prog;
    logic [CODE_W-1:0] code;
    logic [N_W-1:0]    n;
    logic [M_W-1:0]    m;
  } setting_t;
endpackage

// File: rtl/fsel_strap_latch.sv
module fsel_strap_latch #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample_en,
  input  logic [W-1:0] pins,
  output logic [W-1:0] held
);
  logic [W-1:0] held_d;

  always_comb begin
    held_d = held;
    if (sample_en) held_d = pins;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= '0;
    else        held <= held_d;
  end
endmodule

// File: rtl/fsel_cfg_regs.sv
module fsel_cfg_regs
  import fsel_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [CODE_W-1:0] sw_code,
  output logic              ovr,
  output logic              prog_en,
  output logic [N_W-1:0]    n_reg,
  output logic [M_W-1:0]    m_reg,
  output logic [N_W-1:0]    rn_reg,
  output logic [M_W-1:0]    rm_reg,
  output logic              rsel
);
  logic en_ctrl, en_n, en_m, en_rn, en_rm;

  always_comb begin
    en_ctrl = 1'b0;
    en_n    = 1'b0;
    en_m    = 1'b0;
    en_rn   = 1'b0;
    en_rm   = 1'b0;
    if (we) begin
      case (addr)
        A_CTRL:  en_ctrl = 1'b1;
        A_N:     en_n    = 1'b1;
        A_M:     en_m    = 1'b1;
        A_RN:    en_rn   = 1'b1;
        A_RM:    en_rm   = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_code <= '0;
      ovr     <= 1'b0;
      prog_en <= 1'b0;
      n_reg   <= '0;
      m_reg   <= '0;
      rn_reg  <= '0;
      rm_reg  <= '0;
      rsel    <= 1'b0;
    end else begin
      if (en_ctrl) begin
        sw_code <= wdata[CODE_W-1:0];
        ovr     <= wdata[CTRL_OVR_BIT];
        prog_en <= wdata[CTRL_PROG_BIT];
      end
      if (en_n)  n_reg  <= wdata[N_W-1:0];
      if (en_m)  m_reg  <= wdata[M_W-1:0];
      if (en_rn) rn_reg <= wdata[N_W-1:0];
      if (en_rm) begin
        rm_reg <= wdata[M_W-1:0];
        rsel   <= wdata[RM_SEL_BIT];
      end
    end
  end
endmodule

// File: rtl/fsel_resolve.sv
module fsel_resolve
  import fsel_pkg::*;
(
  input  logic [CODE_W-1:0] strap_q,
  input  logic [CODE_W-1:0] sw_code,
  input  logic              ovr,
  input  logic              prog_en,
  input  logic [N_W-1:0]    n_reg,
  input  logic [M_W-1:0]    m_reg,
  input  logic [N_W-1:0]    rn_reg,
  input  logic [M_W-1:0]    rm_reg,
  input  logic              rsel,
  input  logic              recover,
  output setting_t          cand,
  output logic              invalid
);
  localparam int CMP_W = N_W + 1;

  logic [CODE_W-1:0] picked;

  always_comb begin
    picked = ovr ? sw_code : strap_q;
    cand   = '{prog: 1'b0, code: picked, n: '0, m: '0};
    if (recover) begin
      if (rsel) cand = '{prog: 1'b1, code: picked, n: rn_reg, m: rm_reg};
      else      cand = '{prog: 1'b0, code: strap_q, n: '0, m: '0};
    end else if (prog_en) begin
      cand = '{prog: 1'b1, code: picked, n: n_reg, m: m_reg};
    end
    invalid = cand.prog &&
              (CMP_W'(cand.n) <= CMP_W'(cand.m));
  end
endmodule

// File: rtl/fsel_commit.sv
module fsel_commit
  import fsel_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  setting_t cand,
  input  logic     invalid,
  input  logic     recover,
  output setting_t active,
  output logic     err,
  output logic     pulse
);
  setting_t active_d;
  logic     err_d, pulse_d, take;

  always_comb begin
    take     = !invalid;
    active_d = take ? cand : active;
    err_d    = invalid;
    pulse_d  = take && (cand != active) && !recover;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= '0;
      err    <= 1'b0;
      pulse  <= 1'b0;
    end else begin
      active <= active_d;
      err    <= err_d;
      pulse  <= pulse_d;
    end
  end
endmodule

// File: rtl/clk_src_select.sv
module clk_src_select
  import fsel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic [CODE_W-1:0] strap_code,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              wd_recover,
  output logic [CODE_W-1:0] strap_latched,
  output logic [CODE_W-1:0] ratio_code,
  output logic [N_W-1:0]    cpu_n,
  output logic [M_W-1:0]    cpu_m,
  output logic              prog_mode,
  output logic              setting_err,
  output logic              freq_change
);
  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync[SYNC_STAGES-1];

  logic [CODE_W-1:0] sw_code;
  logic              ovr, prog_en, rsel, invalid;
  logic [N_W-1:0]    n_reg, rn_reg;
  logic [M_W-1:0]    m_reg, rm_reg;
  setting_t          cand, active;

  fsel_strap_latch #(.W(CODE_W)) u_strap (
    .clk(clk), .rst_n(rst_int_n), .sample_en(pwr_good),
    .pins(strap_code), .held(strap_latched)
  );

  fsel_cfg_regs u_regs (
    .clk(clk), .rst_n(rst_int_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .sw_code(sw_code), .ovr(ovr), .prog_en(prog_en),
    .n_reg(n_reg), .m_reg(m_reg), .rn_reg(rn_reg), .rm_reg(rm_reg),
    .rsel(rsel)
  );

  fsel_resolve u_res (
    .strap_q(strap_latched), .sw_code(sw_code), .ovr(ovr),
    .prog_en(prog_en), .n_reg(n_reg), .m_reg(m_reg), .rn_reg(rn_reg),
    .rm_reg(rm_reg), .rsel(rsel), .recover(wd_recover),
    .cand(cand), .invalid(invalid)
  );

  fsel_commit u_commit (
    .clk(clk), .rst_n(rst_int_n), .cand(cand), .invalid(invalid),
    .recover(wd_recover), .active(active), .err(setting_err),
    .pulse(freq_change)
  );

  assign ratio_code = active.code;
  assign cpu_n      = active.n;
  assign cpu_m      = active.m;
  assign prog_mode  = active.prog;
endmodule

// File: rtl/clk_src_select_chk.sv
module clk_src_select_chk
  import fsel_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              pwr_good,
  input logic              wd_recover,
  input logic [CODE_W-1:0] strap_latched,
  input logic [CODE_W-1:0] ratio_code,
  input logic [N_W-1:0]    cpu_n,
  input logic [M_W-1:0]    cpu_m,
  input logic              prog_mode,
  input logic              setting_err,
  input logic              freq_change
);
  logic pv;
  logic [CODE_W+N_W+M_W:0] bundle;

  assign bundle = {prog_mode, ratio_code, cpu_n, cpu_m};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pv <= 1'b0;
    else        pv <= 1'b1;
  end

  p_strap_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pv && !$past(pwr_good) |-> $stable(strap_latched));

  p_fixed_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_mode |-> (cpu_n == '0) && (cpu_m == '0));

  p_valid_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    prog_mode |-> ({1'b0, cpu_n} > {2'b00, cpu_m}));

  p_err_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pv && setting_err |-> $stable(bundle));

  p_pulse_real_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pv && freq_change |-> !$stable(bundle));

  p_quiet_recovery_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pv && $past(wd_recover) |-> !freq_change);
endmodule

bind clk_src_select clk_src_select_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .wd_recover(wd_recover),
  .strap_latched(strap_latched), .ratio_code(ratio_code), .cpu_n(cpu_n),
  .cpu_m(cpu_m), .prog_mode(prog_mode), .setting_err(setting_err),
  .freq_change(freq_change)
);

// File: tb/sim_clk_src_select.sv
`timescale 1ns/1ps
module sim_clk_src_select;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_good = 1'b0;
  logic [4:0] strap_code = '0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       wd_recover = 1'b0;
  logic [4:0] strap_latched, ratio_code;
  logic [7:0] cpu_n;
  logic [6:0] cpu_m;
  logic       prog_mode, setting_err, freq_change;

  int nchk = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  clk_src_select u0 (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .strap_code(strap_code),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .wd_recover(wd_recover), .strap_latched(strap_latched),
    .ratio_code(ratio_code), .cpu_n(cpu_n), .cpu_m(cpu_m),
    .prog_mode(prog_mode), .setting_err(setting_err),
    .freq_change(freq_change)
  );

  typedef struct packed {
    logic [2:0] addr;
    logic [7:0] data;
    logic       rec;
    logic [4:0] strap;
    logic       pg;
    logic [4:0] x_strap;
    logic [4:0] x_code;
    logic [7:0] x_n;
    logic [6:0] x_m;
    logic       x_prog;
    logic       x_err;
    logic       x_pulse;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{3'd7, 8'hFF, 1'b0, 5'h0A, 1'b1, 5'h0A, 5'h0A, 8'h00, 7'h00, 1'b0, 1'b0, 1'b1},
    '{3'd5, 8'h55, 1'b0, 5'h1F, 1'b0, 5'h0A, 5'h0A, 8'h00, 7'h00, 1'b0, 1'b0, 1'b0},
    '{3'd0, 8'h33, 1'b0, 5'h1F, 1'b0, 5'h0A, 5'h13, 8'h00, 7'h00, 1'b0, 1'b0, 1'b1},
    '{3'd0, 8'h13, 1'b0, 5'h1F, 1'b0, 5'h0A, 5'h0A, 8'h00, 7'h00, 1'b0, 1'b0, 1'b1},
    '{3'd1, 8'h64, 1'b0, 5'h1F, 1'b0, 5'h0A, 5'h0A, 8'h00, 7'h00, 1'b0, 1'b0, 1'b0},
    '{3'd2, 8'h2D, 1'b0, 5'h1F, 1'b0, 5'h0A, 5'h0A, 8'h00, 7'h00, 1'b0, 1'b0, 1'b0},
    '{3'd0, 8'h53, 1'b0, 5'h1F, 1'b0, 5'h0A, 5'h0A, 8'h64, 7'h2D, 1'b1, 1'b0, 1'b1},
    '{3'd1, 8'h80, 1'b0, 5'h1F, 1'b0, 5'h0A, 5'h0A, 8'h80, 7'h2D, 1'b1, 1'b0, 1'b1},
    '{3'd2, 8'h10, 1'b0, 5'h1F, 1'b0, 5'h0A, 5'h0A, 8'h80, 7'h10, 1'b1, 1'b0, 1'b1},
    '{3'd2, 8'h7F, 1'b0, 5'h1F, 1'b0, 5'h0A, 5'h0A, 8'h80, 7'h7F, 1'b1, 1'b0, 1'b1},
    '{3'd1, 8'h7F, 1'b0, 5'h1F, 1'b0, 5'h0A, 5'h0A, 8'h80, 7'h7F, 1'b1, 1'b1, 1'b0},
    '{3'd1, 8'h20, 1'b0, 5'h1F, 1'b0, 5'h0A, 5'h0A, 8'h80, 7'h7F, 1'b1, 1'b1, 1'b0},
    '{3'd2, 8'h05, 1'b0, 5'h1F, 1'b0, 5'h0A, 5'h0A, 8'h20, 7'h05, 1'b1, 1'b0, 1'b1},
    '{3'd2, 8'h05, 1'b0, 5'h1F, 1'b0, 5'h0A, 5'h0A, 8'h20, 7'h05, 1'b1, 1'b0, 1'b0},
    '{3'd3, 8'h90, 1'b0, 5'h1F, 1'b0, 5'h0A, 5'h0A, 8'h20, 7'h05, 1'b1, 1'b0, 1'b0},
    '{3'd4, 8'h91, 1'b0, 5'h1F, 1'b0, 5'h0A, 5'h0A, 8'h20, 7'h05, 1'b1, 1'b0, 1'b0},
    '{3'd6, 8'h00, 1'b1, 5'h1F, 1'b0, 5'h0A, 5'h0A, 8'h90, 7'h11, 1'b1, 1'b0, 1'b0},
    '{3'd0, 8'h73, 1'b1, 5'h1F, 1'b0, 5'h0A, 5'h13, 8'h90, 7'h11, 1'b1, 1'b0, 1'b0},
    '{3'd4, 8'h11, 1'b1, 5'h1F, 1'b0, 5'h0A, 5'h0A, 8'h00, 7'h00, 1'b0, 1'b0, 1'b0},
    '{3'd7, 8'h00, 1'b0, 5'h1F, 1'b0, 5'h0A, 5'h13, 8'h20, 7'h05, 1'b1, 1'b0, 1'b1}
  };

  function automatic string req_of(int i);
    case (i)
      0:              return "R1 R11";
      1:              return "R1 R11";
      2, 3:           return "R2";
      4, 5:           return "R3";
      6:              return "R4 R8";
      7, 8, 9:        return "R12";
      10, 11, 12:     return "R5";
      13:             return "R8";
      14, 15:         return "R7 R8";
      16:             return "R7 R9";
      17:             return "R7 R9";
      18:             return "R6 R9";
      default:        return "R9";
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] outs();
    return {35'd0, strap_latched, ratio_code, cpu_n, cpu_m,
            prog_mode, setting_err, freq_change};
  endfunction

  function automatic logic [63:0] want(logic [4:0] s, logic [4:0] c,
      logic [7:0] n, logic [6:0] m, logic p, logic e, logic f);
    return {35'd0, s, c, n, m, p, e, f};
  endfunction

  task automatic apply(logic [2:0] a, logic [7:0] d, logic rec,
                       logic [4:0] s, logic pg);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d; strap_code = s; pwr_good = pg;
    @(negedge clk);
    cfg_we = 1'b0; pwr_good = 1'b0; wd_recover = rec;
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    // R10: outputs at zero while reset is held
    repeat (3) @(negedge clk);
    check("R10 in reset", outs(), want(5'h00, 5'h00, 8'h00, 7'h00, 1'b0, 1'b0, 1'b0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 after release", outs(), want(5'h00, 5'h00, 8'h00, 7'h00, 1'b0, 1'b0, 1'b0));

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].addr, VEC[i].data, VEC[i].rec, VEC[i].strap, VEC[i].pg);
      check(req_of(i), outs(),
            want(VEC[i].x_strap, VEC[i].x_code, VEC[i].x_n, VEC[i].x_m,
                 VEC[i].x_prog, VEC[i].x_err, VEC[i].x_pulse));
    end

    // R1: pwr_good held across two strap values keeps the last one
    @(negedge clk);
    pwr_good = 1'b1; strap_code = 5'h03;
    @(negedge clk);
    strap_code = 5'h1C;
    @(negedge clk);
    pwr_good = 1'b0; strap_code = 5'h07;
    repeat (2) @(negedge clk);
    check("R1 last strap kept", {59'd0, strap_latched}, 64'h1C);
    // R2: override set, so the ratio code ignores the new straps
    check("R2 override holds code", {59'd0, ratio_code}, 64'h13);

    // R5 boundary: N exactly M+1 is the smallest valid pair
    apply(3'd2, 8'h1F, 1'b0, 5'h07, 1'b0);
    check("R5 boundary valid", outs(),
          want(5'h1C, 5'h13, 8'h20, 7'h1F, 1'b1, 1'b0, 1'b1));

    // R10: mid-run reset clears everything, override included
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10 async clear", outs(), want(5'h00, 5'h00, 8'h00, 7'h00, 1'b0, 1'b0, 1'b0));
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    apply(3'd7, 8'h00, 1'b0, 5'h05, 1'b1);
    check("R10 override cleared", outs(),
          want(5'h05, 5'h05, 8'h00, 7'h00, 1'b0, 1'b0, 1'b1));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule